// File: doc/BRIEF.md
# Multithreaded Decode Stage Controller

This block is the per-thread control of an instruction decode stage that sits between fetch and rename. Each cycle it receives a bundle of up to `FW` fetch slots; every slot carries a thread number, a sequence number and a kill flag. Up to `DW` live instructions are passed on to rename through a slot vector with one valid bit per slot. Thread 0 is served first, then thread 1, and so on, until the decode budget is used up. Opcode decoding and renaming happen elsewhere. Here an instruction is only a sequence number tagged with its thread.

Each thread runs its own five-state machine, reported on `thr_state` as IDLE=0, ACTIVE=1, HELD=2, DRAIN=3 and FLUSH=4. It also keeps three sticky stall flags, one each for rename, execute and commit. When a thread cannot forward everything it holds, the remainder goes into a private skid FIFO of depth `FETCH_DELAY*FW+DW`, and the thread tells fetch to stop with a one-cycle `fetch_hold` pulse. Once its stalls clear, the thread drains the FIFO in order and then releases fetch with a one-cycle `fetch_release` pulse. A squash from commit empties the thread's FIFO and discards its arrivals.

Transitions: IDLE/ACTIVE→HELD (stall or leftover), HELD→DRAIN (all flags clear), DRAIN→ACTIVE (FIFO empty), DRAIN→HELD (new stall), any→FLUSH (squash or reorder buffer busy), FLUSH→ACTIVE or IDLE (quiet cycle, with or without arrivals), ACTIVE↔IDLE (arrivals present or absent). Every output, `thr_state` included, is registered and reflects the inputs of the previous cycle.

Top module: `dcs_decode_ctl`

## Requirements
- R1: After reset every thread is IDLE (code 0), `dec_vld`, `fetch_hold` and `fetch_release` are all zero.
- R2: Live fetch slots appear one cycle later in rename slots. They are packed from slot 0 upward, lower thread numbers first, and each thread keeps its fetch order. A thread that forwards goes to ACTIVE (code 1).
- R3: When a running thread has more arrivals than the decode budget left to it, it forwards what fits, parks the rest, enters HELD (code 2) and pulses `fetch_hold` for that thread.
- R4: A stall-set pulse on any of the three sources puts the thread in HELD and parks its arrivals. `fetch_hold` pulses only if the thread was not already HELD or DRAIN. The thread stays HELD until all of its set flags have been cleared.
- R5: A stall-clear pulse for a flag that is not set has no effect on state or forwarding.
- R6: A HELD thread with every flag clear enters DRAIN (code 3) in the same cycle and forwards skid entries oldest first, within its budget, while appending new arrivals. When the FIFO would be left empty, it pulses `fetch_release` and goes ACTIVE.
- R7: A stall raised while a thread is in DRAIN returns it to HELD without a new `fetch_hold` pulse.
- R8: A commit squash overrides stalls and everything else. The thread goes to FLUSH (code 4), its skid contents and same-cycle arrivals are discarded and nothing of it is forwarded. It pulses `fetch_release` only if it was HELD or DRAIN, and never pulses `fetch_hold` in that cycle.
- R9: While the reorder-buffer-busy input is high the thread stays in FLUSH. On a later quiet cycle it leaves FLUSH to ACTIVE if it has arrivals, otherwise to IDLE.
- R10: Killed fetch slots are dropped and consume no rename slot.
- R11: A skid FIFO never holds more than `FETCH_DELAY*FW+DW` entries.
- R12: A running thread with no arrivals goes to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | FW | Fetch slot valid |
| fetch_tid | input | FW*TID_W | Thread of each fetch slot |
| fetch_seq | input | FW*SEQ_W | Sequence number of each fetch slot |
| fetch_kill | input | FW | Slot already squashed |
| ren_stall_set | input | NT | Rename stall set pulse per thread |
| ren_stall_clr | input | NT | Rename stall clear pulse per thread |
| exe_stall_set | input | NT | Execute stall set pulse per thread |
| exe_stall_clr | input | NT | Execute stall clear pulse per thread |
| cmt_stall_set | input | NT | Commit stall set pulse per thread |
| cmt_stall_clr | input | NT | Commit stall clear pulse per thread |
| cmt_squash | input | NT | Squash request per thread |
| rob_busy | input | NT | Reorder buffer still squashing per thread |
| dec_vld | output | DW | Rename slot valid |
| dec_tid | output | DW*TID_W | Thread of each rename slot |
| dec_seq | output | DW*SEQ_W | Sequence number of each rename slot |
| fetch_hold | output | NT | One-cycle block pulse to fetch |
| fetch_release | output | NT | One-cycle unblock pulse to fetch |
| thr_state | output | NT*3 | Per-thread state code |

## Verification
The hardest case to reach is a budget overflow. With fetch and decode equally wide, one thread alone can never bring more than the decode budget. Leftover instructions appear only when a lower-numbered thread is draining its skid FIFO and uses the whole budget in the same cycle that a higher thread receives a full bundle. The stimulus stalls thread 0 across two full bundles so that its FIFO reaches capacity. It then clears the stall in the very cycle thread 1 gets two instructions. This drives thread 1 into HELD by overflow and then sends it through its own DRAIN, and the full FIFO is observed on the way.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [2:0] {
        TS_IDLE   = 3'd0,
        TS_ACTIVE = 3'd1,
        TS_HELD   = 3'd2,
        TS_DRAIN  = 3'd3,
        TS_FLUSH  = 3'd4
    } thr_state_e;

    localparam int STALL_SRCS = 3;

endpackage

// File: rtl/dcs_stall_flags.sv
module dcs_stall_flags #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic            any_next_o
);

    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] flags_d;

    // a clear pulse on a flag that is not set leaves it clear
    assign flags_d    = (flags_q | set_i) & ~clr_i;
    assign any_next_o = |flags_d;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/dcs_skid_fifo.sv
module dcs_skid_fifo #(
    parameter int DEPTH  = 4,
    parameter int SEQ_W  = 16,
    parameter int N_PUSH = 2,
    parameter int N_POP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  int               push_cnt_i,
    input  logic [SEQ_W-1:0] push_data_i [N_PUSH],
    input  int               pop_cnt_i,
    output int               level_o,
    output logic [SEQ_W-1:0] head_o [N_POP]
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [SEQ_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;
    int               pop_eff;
    int               push_eff;
    int               room;

    always_comb begin
        pop_eff  = (pop_cnt_i < int'(cnt_q)) ? pop_cnt_i : int'(cnt_q);
        room     = DEPTH - (int'(cnt_q) - pop_eff);
        push_eff = (push_cnt_i < room) ? push_cnt_i : room;
    end

    assign level_o = int'(cnt_q);

    generate
        for (genvar j = 0; j < N_POP; j++) begin : g_peek
            assign head_o[j] = mem[PTR_W'((int'(head_q) + j) % DEPTH)];
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_PUSH; i++) begin
            if (!flush_i && i < push_eff)
                mem[PTR_W'((int'(head_q) + int'(cnt_q) + i) % DEPTH)] <= push_data_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= PTR_W'((int'(head_q) + pop_eff) % DEPTH);
            cnt_q  <= CNT_W'(int'(cnt_q) - pop_eff + push_eff);
        end
    end

endmodule

// File: rtl/dcs_thread_ctl.sv
module dcs_thread_ctl
    import dcs_pkg::*;
#(
    parameter int FW    = 2,
    parameter int DW    = 2,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             squash_i,
    input  logic             rob_busy_i,
    input  logic             stall_i,
    input  int               in_cnt_i,
    input  logic [SEQ_W-1:0] in_data_i [FW],
    input  int               skid_lvl_i,
    input  logic [SEQ_W-1:0] skid_head_i [DW],
    input  int               budget_i,
    output thr_state_e       state_o,
    output int               fwd_cnt_o,
    output logic [SEQ_W-1:0] fwd_data_o [DW],
    output int               push_cnt_o,
    output logic [SEQ_W-1:0] push_data_o [FW],
    output int               pop_cnt_o,
    output logic             flush_o,
    output logic             hold_o,
    output logic             release_o
);

    thr_state_e state_q;
    thr_state_e state_d;
    thr_state_e eff;
    logic       use_skid;
    int         take;
    int         left;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // decisions and outputs
    always_comb begin
        state_d    = state_q;
        eff        = state_q;
        use_skid   = 1'b0;
        take       = 0;
        left       = 0;
        fwd_cnt_o  = 0;
        pop_cnt_o  = 0;
        push_cnt_o = 0;
        flush_o    = 1'b0;
        hold_o     = 1'b0;
        release_o  = 1'b0;
        for (int i = 0; i < FW; i++) push_data_o[i] = in_data_i[i];

        if (squash_i) begin
            state_d   = TS_FLUSH;
            flush_o   = 1'b1;
            release_o = (state_q == TS_HELD) || (state_q == TS_DRAIN);
        end else if (rob_busy_i) begin
            state_d = TS_FLUSH;
        end else if (stall_i) begin
            state_d    = TS_HELD;
            push_cnt_o = in_cnt_i;
            hold_o     = (state_q != TS_HELD) && (state_q != TS_DRAIN);
        end else begin
            unique case (state_q)
                TS_HELD:  eff = TS_DRAIN;
                TS_FLUSH: eff = TS_ACTIVE;
                default:  eff = state_q;
            endcase
            unique case (eff)
                TS_DRAIN: begin
                    use_skid   = 1'b1;
                    take       = (skid_lvl_i < budget_i) ? skid_lvl_i : budget_i;
                    pop_cnt_o  = take;
                    push_cnt_o = in_cnt_i;
                    if (skid_lvl_i - take + in_cnt_i == 0) begin
                        release_o = 1'b1;
                        state_d   = TS_ACTIVE;
                    end else begin
                        state_d   = TS_DRAIN;
                    end
                end
                default: begin
                    take = (in_cnt_i < budget_i) ? in_cnt_i : budget_i;
                    left = in_cnt_i - take;
                    if (left > 0) begin
                        push_cnt_o = left;
                        for (int i = 0; i < FW; i++)
                            push_data_o[i] = (i + take < FW) ? in_data_i[(i + take) % FW] : '0;
                        state_d = TS_HELD;
                        hold_o  = 1'b1;
                    end else begin
                        state_d = (in_cnt_i == 0) ? TS_IDLE : TS_ACTIVE;
                    end
                end
            endcase
            fwd_cnt_o = take;
        end

        for (int j = 0; j < DW; j++) begin
            if (use_skid)    fwd_data_o[j] = skid_head_i[j];
            else if (j < FW) fwd_data_o[j] = in_data_i[j % FW];
            else             fwd_data_o[j] = '0;
        end
    end

endmodule

// File: rtl/dcs_decode_ctl.sv
module dcs_decode_ctl
    import dcs_pkg::*;
#(
    parameter int NT          = 2,
    parameter int DW          = 2,
    parameter int FW          = 2,
    parameter int FETCH_DELAY = 1,
    parameter int SEQ_W       = 16,
    localparam int TID_W      = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FW-1:0]       fetch_vld,
    input  logic [FW*TID_W-1:0] fetch_tid,
    input  logic [FW*SEQ_W-1:0] fetch_seq,
    input  logic [FW-1:0]       fetch_kill,
    input  logic [NT-1:0]       ren_stall_set,
    input  logic [NT-1:0]       ren_stall_clr,
    input  logic [NT-1:0]       exe_stall_set,
    input  logic [NT-1:0]       exe_stall_clr,
    input  logic [NT-1:0]       cmt_stall_set,
    input  logic [NT-1:0]       cmt_stall_clr,
    input  logic [NT-1:0]       cmt_squash,
    input  logic [NT-1:0]       rob_busy,
    output logic [DW-1:0]       dec_vld,
    output logic [DW*TID_W-1:0] dec_tid,
    output logic [DW*SEQ_W-1:0] dec_seq,
    output logic [NT-1:0]       fetch_hold,
    output logic [NT-1:0]       fetch_release,
    output logic [NT*3-1:0]     thr_state
);

    localparam int SKID_DEPTH = FETCH_DELAY * FW + DW;

    int               fwd_cnt_a  [NT];
    logic [SEQ_W-1:0] fwd_data_a [NT][DW];
    int               skid_lvl   [NT];
    logic [NT-1:0]    hold_c;
    logic [NT-1:0]    release_c;

    generate
        for (genvar t = 0; t < NT; t++) begin : g_thr
            logic             stall_any;
            int               in_cnt;
            logic [SEQ_W-1:0] in_data   [FW];
            int               push_cnt;
            logic [SEQ_W-1:0] push_data [FW];
            int               pop_cnt;
            logic             flush;
            int               lvl;
            logic [SEQ_W-1:0] head      [DW];
            int               budget;
            int               fwd_cnt;
            logic [SEQ_W-1:0] fwd_data  [DW];
            thr_state_e       st;

            // gather this thread's live slots in fetch order
            always_comb begin
                int c;
                c = 0;
                for (int i = 0; i < FW; i++) in_data[i] = '0;
                for (int i = 0; i < FW; i++) begin
                    if (fetch_vld[i] && !fetch_kill[i] &&
                        fetch_tid[i*TID_W +: TID_W] == TID_W'(t)) begin
                        in_data[c % FW] = fetch_seq[i*SEQ_W +: SEQ_W];
                        c++;
                    end
                end
                in_cnt = c;
            end

            // budget left after lower-numbered threads
            always_comb begin
                budget = DW;
                for (int k = 0; k < t; k++) budget -= fwd_cnt_a[k];
            end

            dcs_stall_flags #(.NSRC(STALL_SRCS)) u_flags (
                .clk        (clk),
                .rst_n      (rst_n),
                .set_i      ({cmt_stall_set[t], exe_stall_set[t], ren_stall_set[t]}),
                .clr_i      ({cmt_stall_clr[t], exe_stall_clr[t], ren_stall_clr[t]}),
                .any_next_o (stall_any)
            );

            dcs_skid_fifo #(
                .DEPTH (SKID_DEPTH),
                .SEQ_W (SEQ_W),
                .N_PUSH(FW),
                .N_POP (DW)
            ) u_skid (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush_i    (flush),
                .push_cnt_i (push_cnt),
                .push_data_i(push_data),
                .pop_cnt_i  (pop_cnt),
                .level_o    (lvl),
                .head_o     (head)
            );

            dcs_thread_ctl #(
                .FW   (FW),
                .DW   (DW),
                .SEQ_W(SEQ_W)
            ) u_ctl (
                .clk        (clk),
                .rst_n      (rst_n),
                .squash_i   (cmt_squash[t]),
                .rob_busy_i (rob_busy[t]),
                .stall_i    (stall_any),
                .in_cnt_i   (in_cnt),
                .in_data_i  (in_data),
                .skid_lvl_i (lvl),
                .skid_head_i(head),
                .budget_i   (budget),
                .state_o    (st),
                .fwd_cnt_o  (fwd_cnt),
                .fwd_data_o (fwd_data),
                .push_cnt_o (push_cnt),
                .push_data_o(push_data),
                .pop_cnt_o  (pop_cnt),
                .flush_o    (flush),
                .hold_o     (hold_c[t]),
                .release_o  (release_c[t])
            );

            assign fwd_cnt_a[t]         = fwd_cnt;
            assign fwd_data_a[t]        = fwd_data;
            assign skid_lvl[t]          = lvl;
            assign thr_state[t*3 +: 3]  = st;
        end
    endgenerate

    // pack forwarded entries into rename slots, lower threads first
    logic [DW-1:0]    slot_vld;
    logic [TID_W-1:0] slot_tid [DW];
    logic [SEQ_W-1:0] slot_seq [DW];

    always_comb begin
        int base;
        base     = 0;
        slot_vld = '0;
        for (int j = 0; j < DW; j++) begin
            slot_tid[j] = '0;
            slot_seq[j] = '0;
        end
        for (int t = 0; t < NT; t++) begin
            for (int j = 0; j < DW; j++) begin
                if (j < fwd_cnt_a[t] && base + j < DW) begin
                    slot_vld[(base + j) % DW] = 1'b1;
                    slot_tid[(base + j) % DW] = TID_W'(t);
                    slot_seq[(base + j) % DW] = fwd_data_a[t][j];
                end
            end
            base += fwd_cnt_a[t];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld       <= '0;
            dec_tid       <= '0;
            dec_seq       <= '0;
            fetch_hold    <= '0;
            fetch_release <= '0;
        end else begin
            dec_vld       <= slot_vld;
            for (int j = 0; j < DW; j++) begin
                dec_tid[j*TID_W +: TID_W] <= slot_tid[j];
                dec_seq[j*SEQ_W +: SEQ_W] <= slot_seq[j];
            end
            fetch_hold    <= hold_c;
            fetch_release <= release_c;
        end
    end

endmodule

// File: rtl/dcs_decode_ctl_chk.sv
module dcs_decode_ctl_chk
    import dcs_pkg::*;
#(
    parameter int NT    = 2,
    parameter int DW    = 2,
    parameter int DEPTH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NT-1:0]   cmt_squash,
    input logic [DW-1:0]   dec_vld,
    input logic [NT-1:0]   fetch_hold,
    input logic [NT-1:0]   fetch_release,
    input logic [NT*3-1:0] thr_state,
    input int              skid_lvl [NT]
);

    // R2
    dec_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld & (dec_vld + DW'(1))) == '0);

    generate
        for (genvar t = 0; t < NT; t++) begin : g_t
            // R11
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                skid_lvl[t] <= DEPTH);

            // R8
            squash_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cmt_squash[t] |=> thr_state[t*3 +: 3] == TS_FLUSH);

            // R8
            pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(fetch_hold[t] && fetch_release[t]));

            // R3
            hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fetch_hold[t] |-> thr_state[t*3 +: 3] == TS_HELD);

            // R6
            release_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fetch_release[t] |-> (thr_state[t*3 +: 3] == TS_ACTIVE ||
                                      thr_state[t*3 +: 3] == TS_FLUSH));
        end
    endgenerate

endmodule

bind dcs_decode_ctl dcs_decode_ctl_chk #(
    .NT   (NT),
    .DW   (DW),
    .DEPTH(SKID_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmt_squash   (cmt_squash),
    .dec_vld      (dec_vld),
    .fetch_hold   (fetch_hold),
    .fetch_release(fetch_release),
    .thr_state    (thr_state),
    .skid_lvl     (skid_lvl)
);

// File: tb/test_dcs_decode_ctl.sv
module test_dcs_decode_ctl;

    localparam int NT = 2, DW = 2, FW = 2, SEQ_W = 16, TID_W = 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [FW-1:0]       fetch_vld = '0;
    logic [FW*TID_W-1:0] fetch_tid = '0;
    logic [FW*SEQ_W-1:0] fetch_seq = '0;
    logic [FW-1:0]       fetch_kill = '0;
    logic [NT-1:0]       ren_set = '0, ren_clr = '0, exe_set = '0, exe_clr = '0;
    logic [NT-1:0]       cmt_set = '0, cmt_clr = '0, squash = '0, rob = '0;
    logic [DW-1:0]       dec_vld;
    logic [DW*TID_W-1:0] dec_tid;
    logic [DW*SEQ_W-1:0] dec_seq;
    logic [NT-1:0]       hold, rel;
    logic [NT*3-1:0]     thr_state;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dcs_decode_ctl i_dcs_decode_ctl (
        .clk(clk), .rst_n(rst_n),
        .fetch_vld(fetch_vld), .fetch_tid(fetch_tid), .fetch_seq(fetch_seq), .fetch_kill(fetch_kill),
        .ren_stall_set(ren_set), .ren_stall_clr(ren_clr),
        .exe_stall_set(exe_set), .exe_stall_clr(exe_clr),
        .cmt_stall_set(cmt_set), .cmt_stall_clr(cmt_clr),
        .cmt_squash(squash), .rob_busy(rob),
        .dec_vld(dec_vld), .dec_tid(dec_tid), .dec_seq(dec_seq),
        .fetch_hold(hold), .fetch_release(rel), .thr_state(thr_state)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic int st(input int t);
        return int'(thr_state[t*3 +: 3]);
    endfunction

    task automatic chk_slot(input string req, input int j, input int tid, input int seq);
        chk(req, $sformatf("slot%0d tid", j), int'(dec_tid[j*TID_W +: TID_W]), tid);
        chk(req, $sformatf("slot%0d seq", j), int'(dec_seq[j*SEQ_W +: SEQ_W]), seq);
    endtask

    task automatic quiet();
        fetch_vld = '0; fetch_kill = '0; fetch_tid = '0; fetch_seq = '0;
        ren_set = '0; ren_clr = '0; exe_set = '0; exe_clr = '0;
        cmt_set = '0; cmt_clr = '0; squash = '0; rob = '0;
    endtask

    task automatic feed(input int n, input int t0, input int s0, input bit k0,
                        input int t1, input int s1);
        fetch_vld  = (n >= 2) ? 2'b11 : (n == 1) ? 2'b01 : 2'b00;
        fetch_tid  = {t1[0], t0[0]};
        fetch_seq  = {s1[15:0], s0[15:0]};
        fetch_kill = {1'b0, k0};
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic t_reset();
        quiet();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        chk("R1", "state t0", st(0), 0);
        chk("R1", "state t1", st(1), 0);
        chk("R1", "dec_vld", int'(dec_vld), 0);
        chk("R1", "hold", int'(hold), 0);
        chk("R1", "release", int'(rel), 0);
    endtask

    task automatic t_forward();
        feed(2, 0, 10, 0, 0, 11); cyc();
        chk("R2", "dec_vld", int'(dec_vld), 3);
        chk_slot("R2", 0, 0, 10);
        chk_slot("R2", 1, 0, 11);
        chk("R2", "state t0", st(0), 1);
        quiet(); cyc();
        chk("R12", "dec_vld", int'(dec_vld), 0);
        chk("R12", "state t0", st(0), 0);
    endtask

    task automatic t_threads();
        feed(2, 1, 20, 0, 0, 21); cyc();
        chk_slot("R2", 0, 0, 21);
        chk_slot("R2", 1, 1, 20);
        chk("R2", "state t1", st(1), 1);
        quiet(); cyc();
    endtask

    task automatic t_kill();
        feed(2, 0, 30, 1, 0, 31); cyc();
        chk("R10", "dec_vld", int'(dec_vld), 1);
        chk_slot("R10", 0, 0, 31);
        quiet(); cyc();
    endtask

    task automatic t_overflow();
        ren_set[0] = 1'b1; feed(2, 0, 40, 0, 0, 41); cyc();
        chk("R4", "state t0", st(0), 2);
        chk("R4", "hold", int'(hold), 1);
        chk("R4", "dec_vld", int'(dec_vld), 0);
        quiet(); feed(2, 0, 42, 0, 0, 43); cyc();
        chk("R4", "state t0 again", st(0), 2);
        chk("R4", "no second hold", int'(hold), 0);
        quiet(); ren_clr[0] = 1'b1; feed(2, 1, 50, 0, 1, 51); cyc();
        chk("R6", "dec_vld", int'(dec_vld), 3);
        chk_slot("R6", 0, 0, 40);
        chk_slot("R6", 1, 0, 41);
        chk("R6", "state t0", st(0), 3);
        chk("R3", "state t1", st(1), 2);
        chk("R3", "hold", int'(hold), 2);
        quiet(); cyc();
        chk_slot("R11", 0, 0, 42);
        chk_slot("R11", 1, 0, 43);
        chk("R6", "release", int'(rel), 1);
        chk("R6", "state t0", st(0), 1);
        chk("R3", "state t1 drain", st(1), 3);
        cyc();
        chk("R3", "dec_vld", int'(dec_vld), 3);
        chk_slot("R3", 0, 1, 50);
        chk_slot("R3", 1, 1, 51);
        chk("R6", "release t1", int'(rel), 2);
        chk("R6", "state t1", st(1), 1);
        chk("R12", "state t0", st(0), 0);
        cyc();
    endtask

    task automatic t_flags();
        exe_clr[0] = 1'b1; feed(1, 0, 60, 0, 0, 0); cyc();
        chk("R5", "dec_vld", int'(dec_vld), 1);
        chk_slot("R5", 0, 0, 60);
        chk("R5", "state t0", st(0), 1);
        quiet(); cmt_set[1] = 1'b1; exe_set[1] = 1'b1; cyc();
        chk("R4", "state t1", st(1), 2);
        chk("R4", "hold", int'(hold), 2);
        quiet(); exe_clr[1] = 1'b1; cyc();
        chk("R4", "still held", st(1), 2);
        chk("R4", "no release", int'(rel), 0);
        quiet(); cmt_clr[1] = 1'b1; cyc();
        chk("R6", "state t1", st(1), 1);
        chk("R6", "release", int'(rel), 2);
        quiet(); cyc();
    endtask

    task automatic t_drain_stall();
        ren_set[0] = 1'b1; feed(2, 0, 70, 0, 0, 71); cyc();
        chk("R4", "hold", int'(hold), 1);
        quiet(); ren_clr[0] = 1'b1; feed(2, 0, 72, 0, 0, 73); cyc();
        chk_slot("R6", 0, 0, 70);
        chk_slot("R6", 1, 0, 71);
        chk("R6", "state t0", st(0), 3);
        quiet(); exe_set[0] = 1'b1; cyc();
        chk("R7", "state t0", st(0), 2);
        chk("R7", "hold", int'(hold), 0);
        chk("R7", "dec_vld", int'(dec_vld), 0);
        quiet(); exe_clr[0] = 1'b1; cyc();
        chk_slot("R7", 0, 0, 72);
        chk_slot("R7", 1, 0, 73);
        chk("R7", "release", int'(rel), 1);
        quiet(); cyc();
    endtask

    task automatic t_squash();
        ren_set[1] = 1'b1; feed(2, 1, 80, 0, 1, 81); cyc();
        chk("R4", "state t1", st(1), 2);
        quiet(); squash[1] = 1'b1; feed(1, 1, 82, 0, 0, 0); cyc();
        chk("R8", "state t1", st(1), 4);
        chk("R8", "release", int'(rel), 2);
        chk("R8", "hold", int'(hold), 0);
        chk("R8", "dec_vld", int'(dec_vld), 0);
        quiet(); rob[1] = 1'b1; ren_clr[1] = 1'b1; cyc();
        chk("R9", "state t1", st(1), 4);
        chk("R9", "dec_vld", int'(dec_vld), 0);
        quiet(); feed(1, 1, 90, 0, 0, 0); cyc();
        chk("R9", "dec_vld", int'(dec_vld), 1);
        chk_slot("R8", 0, 1, 90);
        chk("R9", "state t1", st(1), 1);
        quiet(); cyc();
        chk("R12", "state t1", st(1), 0);
        squash[0] = 1'b1; feed(2, 0, 95, 0, 1, 96); cyc();
        chk("R8", "state t0", st(0), 4);
        chk("R8", "dec_vld", int'(dec_vld), 1);
        chk_slot("R8", 0, 1, 96);
        chk("R8", "no release", int'(rel), 0);
        quiet(); cyc();
        chk("R9", "state t0", st(0), 0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_forward();
        t_threads();
        t_kill();
        t_overflow();
        t_flags();
        t_drain_stall();
        t_squash();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule